// File: doc/BRIEF.md
# Banked GPIO Port with Gapped Register Map

This block is a general-purpose I/O controller for a configurable number of pins. The pins are grouped in banks of eight lines. Each bank has two 32-bit registers on a simple register bus: a data register and a direction register. Bit k of a bank register controls line 8*bank+k. The CPU writes the direction register to make each line an input or an output. It writes the data register to set the level driven on output lines. When it reads the data register, it sees the live pin level for input lines and the stored value for output lines.

The bank registers sit at a fixed stride of eight bytes. The stride steps over a reserved window at 0x90–0x9F, which is kept free for interrupt control that lives elsewhere. Because of that window, the decode compares the address against each bank's computed location rather than indexing a flat array. Pin inputs pass through a two-stage synchronizer before the read path uses them. To turn a line into an output without a glitch, software writes the data value first and then clears the direction bit.

Top module: `gpbank_port`

## Requirements
- R1: Bank n has its data register at byte address (n+1)*8 and its direction register 4 bytes above. Any base that would be 0x90 or higher is moved up by 0x10. With the default 150 pins this puts banks 0..16 at 0x08..0x88, bank 17 at 0xA0 and bank 18 at 0xA8.
- R2: Some addresses are not bank registers: 0x00–0x07, the window 0x90–0x9F, addresses not on a register boundary, and addresses above the last bank. Reads of these addresses return 0, and writes to them change no register and no pin.
- R3: A direction bit of 1 makes its line an input, and the line's pin_oe bit is then 0. A direction bit of 0 makes the line an output, with pin_oe at 1. pin_out carries the stored data bit on every line, whatever its direction.
- R4: After reset every direction bit is 1 and every data bit is 0. As a result pin_oe is all 0, pin_out is all 0 and bus_rdata is 0.
- R5: A data register read returns, for each line, the synchronized pin level if the line is an input and the stored data bit if it is an output. A direction register read returns the stored direction bits.
- R6: Suppose a pin_in change is applied before clock edge k. Reads whose address is sampled at edge k+1 or earlier return the old level. Reads sampled at edge k+2 or later return the new level.
- R7: Some lines lie at or beyond the pin count, in a partly filled last bank. Their data and direction bits read as 0, and writes to them have no effect. bus_rdata bits 31:8 are always 0, and bus_wdata bits 31:8 are ignored.
- R8: Writing a data bit updates pin_out even while the line is an input. When the direction bit is later cleared, the line drives the written value from the first enabled cycle.
- R9: bus_rdata is registered and returns the register selected by the address sampled at the previous clock edge. A write takes effect on pin_out and pin_oe at the edge where bus_we is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data; only bits 7:0 are used |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| pin_in | input | NUM_PINS (150) | Asynchronous pin levels |
| pin_out | output | NUM_PINS (150) | Output level for each line |
| pin_oe | output | NUM_PINS (150) | Output enable for each line, 1 = drive |

## Verification
Register reads are due exactly one cycle after the address is presented. The scoreboard queues each expected word when the read is launched and compares it on the falling edge that follows the next rising edge. Writes show up on pin_out and pin_oe at the rising edge that samples them, so the pin checks happen on the falling edge right after that write cycle. A change on pin_in needs two edges of synchronizer delay plus the read register. The bench therefore checks that a read sampled one edge after the change still returns the old level, then reads again after enough edges have passed and expects the new level.

// File: rtl/gpbank_pkg.sv
package gpbank_pkg;

    localparam int unsigned BANK_LINES = 8;
    localparam int unsigned BUS_W      = 32;
    localparam int unsigned BANK_STEP  = 8;
    localparam int unsigned DIR_OFS    = 4;
    localparam int unsigned HOLE_LO    = 'h90;
    localparam int unsigned HOLE_SPAN  = 'h10;

    typedef logic [BANK_LINES-1:0] lane_t;
    typedef logic [BUS_W-1:0]      word_t;

    typedef struct packed {
        logic  data;
        logic  dir;
    } bank_sel_t;

    function automatic int unsigned bank_count(int unsigned pins);
        return (pins + BANK_LINES - 1) / BANK_LINES;
    endfunction

    function automatic int unsigned bank_base(int unsigned b);
        int unsigned a;
        a = (b + 1) * BANK_STEP;
        if (a >= HOLE_LO)
            a = a + HOLE_SPAN;
        return a;
    endfunction

    function automatic int unsigned bank_lines(int unsigned pins, int unsigned b);
        int unsigned rem;
        rem = pins - b * BANK_LINES;
        return (rem > BANK_LINES) ? BANK_LINES : rem;
    endfunction

endpackage

// File: rtl/gpbank_sync.sv
module gpbank_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    // R6: the second stage only ever takes what the first held one edge earlier
    a_r6_two_stage: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |=> (stage2_q == $past(stage1_q)));

endmodule

// File: rtl/gpbank_decode.sv
module gpbank_decode
    import gpbank_pkg::*;
#(
    parameter int unsigned NBANKS = 19,
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output bank_sel_t         sel [NBANKS]
);
    for (genvar b = 0; b < NBANKS; b++) begin : g_cmp
        localparam int unsigned BASE = bank_base(b);
        assign sel[b].data = (addr == ADDR_W'(BASE));
        assign sel[b].dir  = (addr == ADDR_W'(BASE + DIR_OFS));
    end

endmodule

// File: rtl/gpbank_lane.sv
module gpbank_lane
    import gpbank_pkg::*;
#(
    parameter int unsigned LINES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_data,
    input  logic             wr_dir,
    input  logic [LINES-1:0] wdata,
    input  logic [LINES-1:0] pin_sync,
    output logic [LINES-1:0] out_val,
    output logic [LINES-1:0] dir_bits,
    output lane_t            rd_data,
    output lane_t            rd_dir
);
    logic [LINES-1:0] data_q;
    logic [LINES-1:0] dir_q;
    logic [LINES-1:0] mix;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '1;
        end else begin
            if (wr_data)
                data_q <= wdata;
            if (wr_dir)
                dir_q <= wdata;
        end
    end

    always_comb begin
        for (int i = 0; i < LINES; i++)
            mix[i] = dir_q[i] ? pin_sync[i] : data_q[i];
    end

    assign out_val  = data_q;
    assign dir_bits = dir_q;
    assign rd_data  = lane_t'(mix);
    assign rd_dir   = lane_t'(dir_q);

    // R2: without a write strobe the stored bits do not move
    a_r2_data_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_data |=> $stable(data_q));
    a_r2_dir_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_dir |=> $stable(dir_q));

endmodule

// File: rtl/gpbank_port.sv
module gpbank_port
    import gpbank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 150,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    localparam int unsigned NBANKS = bank_count(NUM_PINS);

    bank_sel_t             sel     [NBANKS];
    lane_t                 rd_data [NBANKS];
    lane_t                 rd_dir  [NBANKS];
    logic [NUM_PINS-1:0]   pin_sync;
    logic [NUM_PINS-1:0]   dir_bits;
    logic [NBANKS-1:0]     hit_data;
    logic [NBANKS-1:0]     hit_dir;
    word_t                 rd_next;
    logic                  unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:BANK_LINES];

    gpbank_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpbank_decode #(.NBANKS(NBANKS), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        localparam int unsigned LO = b * BANK_LINES;
        localparam int unsigned N  = bank_lines(NUM_PINS, b);

        assign hit_data[b] = sel[b].data;
        assign hit_dir[b]  = sel[b].dir;

        gpbank_lane #(.LINES(N)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .wr_data  (bus_we && sel[b].data),
            .wr_dir   (bus_we && sel[b].dir),
            .wdata    (bus_wdata[N-1:0]),
            .pin_sync (pin_sync[LO +: N]),
            .out_val  (pin_out[LO +: N]),
            .dir_bits (dir_bits[LO +: N]),
            .rd_data  (rd_data[b]),
            .rd_dir   (rd_dir[b])
        );
    end

    assign pin_oe = ~dir_bits;

    always_comb begin
        rd_next = '0;
        for (int b = 0; b < NBANKS; b++) begin
            if (sel[b].data)
                rd_next = rd_next | word_t'(rd_data[b]);
            if (sel[b].dir)
                rd_next = rd_next | word_t'(rd_dir[b]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else
            bus_rdata <= rd_next;
    end

    // R1: the stride decode never selects two registers at once
    a_r1_single_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit_data, hit_dir}));

    // R2: the reserved window always reads back as zero
    a_r2_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= ADDR_W'(HOLE_LO) && bus_addr < ADDR_W'(HOLE_LO + HOLE_SPAN))
        |=> (bus_rdata == '0));

    // R7: upper read bits stay clear
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[BUS_W-1:BANK_LINES] == '0);

    // R4: leaving reset, no line drives
    a_r4_reset_inputs: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0));

endmodule

// File: tb/tb_gpbank_port.sv
module tb_gpbank_port;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 150;
    localparam int NB = 19;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [NP-1:0] m_data = '0;
    logic [NP-1:0] m_dir  = '1;

    int    exp_q[$];
    string tag_q[$];
    logic  rd_req = 1'b0;
    logic  launched = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpbank_port dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // bank n data sits at 8(n+1); from bank 17 on the map jumps by 16
    function automatic int locate(int a, output bit is_dir);
        int base;
        is_dir = 1'b0;
        for (int k = 0; k < NB; k++) begin
            base = (k < 17) ? 8 * (k + 1) : 'hA0 + 8 * (k - 17);
            if (a == base) return k;
            if (a == base + 4) begin is_dir = 1'b1; return k; end
        end
        return -1;
    endfunction

    function automatic int model_read(int a, logic [NP-1:0] pins);
        bit d;
        int k;
        int r;
        k = locate(a, d);
        r = 0;
        if (k < 0) return 0;
        for (int j = 0; j < 8; j++) begin
            int p;
            p = k * 8 + j;
            if (p < NP) begin
                if (d) r[j] = m_dir[p];
                else   r[j] = m_dir[p] ? pins[p] : m_data[p];
            end
        end
        return r;
    endfunction

    task automatic check(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(int a, int d);
        bit isd;
        int k;
        @(negedge clk);
        bus_addr  = 8'(a);
        bus_we    = 1'b1;
        bus_wdata = 32'(d);
        k = locate(a, isd);
        if (k >= 0) begin
            for (int j = 0; j < 8; j++) begin
                int p;
                p = k * 8 + j;
                if (p < NP) begin
                    if (isd) m_dir[p]  = d[j];
                    else     m_data[p] = d[j];
                end
            end
        end
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(int a, int exp, string tag);
        @(negedge clk);
        bus_addr = 8'(a);
        bus_we   = 1'b0;
        rd_req   = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic read_model(int a, string tag);
        bus_read(a, model_read(a, pin_in), tag);
    endtask

    task automatic check_pins(string tag);
        check({tag, " pin_out"}, pin_out, m_data);
        check({tag, " pin_oe"}, pin_oe, ~m_dir);
    endtask

    always @(posedge clk) launched <= rd_req;

    // monitor: compares each launched read one half cycle after its result edge
    always @(negedge clk) begin
        if (launched && exp_q.size() > 0) begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compared++;
            if (bus_rdata !== 32'(e)) begin
                mismatched++;
                $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, 32'(e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] old_pins;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4 reset state
        check("R4 reset", pin_out, '0);
        check("R4 reset oe", pin_oe, '0);
        check("R4 rdata", NP'(bus_rdata), '0);
        bus_read('h0C, 'hFF, "R4 bank0 dir reset");
        bus_read('hAC, 'h3F, "R7 partial bank dir reset");

        for (int i = 0; i < NP; i++) pin_in[i] = ((i * 5) % 3) == 1;
        pin_in[7:0] = 8'h3C;
        repeat (4) @(negedge clk);

        // R8 data written while input reaches pin_out
        bus_write('h08, 'hDEADBEA5);
        check_pins("R8 data while input");
        read_model('h08, "R5 input lines show pins");
        // R3 partial output
        bus_write('h0C, 'h000000F0);
        check_pins("R3 low nibble outputs");
        bus_read('h08, 'h35, "R5 mixed bank0");
        bus_read('h0C, 'hF0, "R5 dir readback");

        // R8 bank2 glitch-free switch
        bus_write('h18, 'h5A);
        check_pins("R8 bank2 data first");
        bus_write('h1C, 'h00);
        check("R8 bank2 drives written", NP'(pin_out[23:16]), NP'(8'h5A));
        check_pins("R8 bank2 enabled");

        // R1 map across the gap
        bus_write('h88, 'h11);
        bus_write('h8C, 'h0F);
        bus_write('hA0, 'h22);
        bus_write('hA4, 'h00);
        check_pins("R1 banks 16 and 17");
        read_model('h88, "R1 bank16 data");
        bus_read('h8C, 'h0F, "R1 bank16 dir");
        bus_read('hA0, 'h22, "R1 bank17 data");
        bus_read('hA4, 'h00, "R1 bank17 dir");

        // R2 hole and unmapped writes do nothing
        bus_write('h90, 'hFF);
        bus_write('h94, 'hFF);
        bus_write('h9C, 'h00);
        bus_write('h04, 'h00);
        bus_write('h09, 'h00);
        bus_write('hB0, 'h00);
        check_pins("R2 ignored writes");
        bus_read('h90, 0, "R2 hole read");
        bus_read('h9C, 0, "R2 hole top read");
        bus_read('h00, 0, "R2 below bank0");
        bus_read('h89, 0, "R2 misaligned");
        bus_read('hB0, 0, "R2 past last bank");
        bus_read('hA4, 'h00, "R2 bank17 dir untouched");

        // R7 partial last bank
        bus_write('hA8, 'hFFFFFFFF);
        bus_write('hAC, 'hFFFFFF00);
        check_pins("R7 partial bank");
        bus_read('hA8, 'h3F, "R7 data upper lines zero");
        bus_read('hAC, 'h00, "R7 dir readback");

        // R6 synchronizer latency on bank1 (all inputs)
        old_pins = pin_in;
        pin_in[15:8] = 8'hC3;
        bus_read('h10, model_read('h10, old_pins), "R6 old level one edge later");
        read_model('h10, "R6 new level after sync");

        // R9 read sees address of previous edge, back to back data pattern
        pin_in[15:8] = 8'h81;
        repeat (3) @(negedge clk);
        read_model('h10, "R9 bank1 read");
        read_model('h18, "R9 bank2 read");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule